// File: doc/BRIEF.md
# Request Stream Protocol Checker

This block sits passively beside a wide valid/ready request stream and watches for breaches of the transfer rules. A beat moves only when valid and ready are both high. While a beat is stalled, the sender must keep valid up and must not change the beat's data or sideband. A packet must not have gaps in valid. The abort flag may not be raised on the beat that opens a packet. Once raised, the abort flag must stay up until ready is seen. The start and end flags must carry legal codes.

Each rule has its own sticky error bit, cleared only by reset. The checker drives nothing back into the stream. To tell opening beats from later beats, it follows packet boundaries. With `STRADDLE=0`, a start is implied after each `beat_last`, and a packet holds at most one start per beat. With `STRADDLE=1`, two packets may share a beat, and only the start and end flags mark the boundaries. In that mode `beat_last` is ignored. The checker also pulses `pkt_dropped` when a packet that was aborted at any point closes, because such a packet would be nullified downstream.

Top module: `rq_stream_checker`

## Requirements
- R1: After reset, all bits of `err_flags` and `pkt_dropped` are 0.
- R2: Valid falling in the cycle after a stalled beat (valid high, ready low) sets `err_flags[0]`.
- R3: Data, last, start/end flags or lane codes changing in the cycle after a stalled beat, while valid stays high, sets `err_flags[1]`.
- R4: Valid low while a packet is open sets `err_flags[2]`.
- R5: An abort on a transferred beat with no packet open sets `err_flags[3]`. In straddle mode, an abort on a transferred beat that also carries any start flag sets the same bit.
- R6: Abort high with valid low sets `err_flags[4]`. Abort falling in the cycle after a stalled beat that carried it also sets `err_flags[4]`.
- R7: In straddle mode, a transferred beat sets `err_flags[5]` if it carries any of these reserved codes:
  - `start_flags` = 2'b10.
  - `end_flags` = 2'b10.
  - `start0_lane` with bit 0 set while `start_flags[0]` is high. The legal codes are 2'b00 for lane 0 and 2'b10 for the upper half.
  - `start1_lane` other than 2'b10 while `start_flags[1]` is high.
- R8: A transferred beat sets `err_flags[6]` (framing) in these cases:
  - Non-straddle: `start_flags[0]` arrives while a packet is open.
  - Straddle: the count of open packets, after one end-before-start inside the beat, would leave the range 0..1.
  - Straddle: data arrives with no packet open and no start.
- R9: In non-straddle mode, a transferred beat with no packet open and `start_flags[0]` low sets `err_flags[7]`.
- R10: `pkt_dropped` is high for exactly one cycle after the transfer that closes a packet which carried an abort on any of its non-first transferred beats. This holds whether the abort was still high at the close or had dropped earlier.
- R11: Error bits never clear except on reset, and compliant traffic sets none of them.
- R12: Packet state advances only on transfers. A stalled beat with `beat_last` high does not close the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| beat_valid | input | 1 | Sender has a beat on the bus |
| beat_ready | input | 1 | Receiver accepts the beat |
| beat_data | input | DATA_W | Beat payload |
| beat_last | input | 1 | Final beat of a packet (non-straddle only) |
| start_flags | input | 2 | Packet starts in this beat: bit 0 first, bit 1 second |
| start0_lane | input | 2 | Start position of first packet: 00 lane 0, 10 upper half |
| start1_lane | input | 2 | Start position of second packet: 10 upper half |
| end_flags | input | 2 | Packet ends in this beat: bit 0 first, bit 1 second |
| abort_req | input | 1 | Sender aborts the current packet |
| err_flags | output | 8 | Sticky error bits as listed in R2..R9 |
| pkt_dropped | output | 1 | Pulse: an aborted packet has closed |

## Verification
The bench builds two copies with `DATA_W=64`: one with `STRADDLE=0` and one with `STRADDLE=1`. A narrow bus keeps the held-beat comparison cheap while it still covers every sideband field. The non-straddle copy reaches the implied start after `beat_last`, the missing-start error and stalled-last handling. The straddle copy reaches two starts in one beat, end-then-start sequences, the reserved codes, and an abort that shares a beat with a start.

// File: rtl/rq_stream_checker.sv
module rq_stream_checker #(
  parameter int DATA_W   = 512,
  parameter bit STRADDLE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_valid,
  input  logic              beat_ready,
  input  logic [DATA_W-1:0] beat_data,
  input  logic              beat_last,
  input  logic [1:0]        start_flags,
  input  logic [1:0]        start0_lane,
  input  logic [1:0]        start1_lane,
  input  logic [1:0]        end_flags,
  input  logic              abort_req,
  output logic [7:0]        err_flags,
  output logic              pkt_dropped
);

  localparam int E_VDROP  = 0;
  localparam int E_UNSTAB = 1;
  localparam int E_GAP    = 2;
  localparam int E_ABFRST = 3;
  localparam int E_ABHOLD = 4;
  localparam int E_RSVD   = 5;
  localparam int E_FRAME  = 6;
  localparam int E_NOSTRT = 7;
  localparam int BW       = DATA_W + 9;

  logic          xfer, stall;
  logic          prev_stall, prev_abort;
  logic [BW-1:0] bundle, prev_bundle;
  logic          in_pkt, aborted;
  logic          closes, next_open, abort_first, rsvd_hit, frame_hit, nostrt_hit;
  logic          abort_counts, drop_now;
  logic [7:0]    hit;

  assign xfer   = beat_valid & beat_ready;
  assign stall  = beat_valid & ~beat_ready;
  assign bundle = {beat_data, beat_last, start_flags, start0_lane, start1_lane, end_flags};

  generate
    if (STRADDLE) begin : g_straddle
      logic [1:0]        n_start, n_end;
      logic signed [3:0] n_open;
      assign n_start     = {1'b0, start_flags[0]} + {1'b0, start_flags[1]};
      assign n_end       = {1'b0, end_flags[0]} + {1'b0, end_flags[1]};
      assign n_open      = $signed({3'b000, in_pkt}) + $signed({2'b00, n_start})
                           - $signed({2'b00, n_end});
      assign frame_hit   = xfer & ((n_open < 4'sd0) | (n_open > 4'sd1) |
                                   (~in_pkt & (n_start == 2'd0)));
      assign rsvd_hit    = xfer & ((start_flags == 2'b10) | (end_flags == 2'b10) |
                                   (start_flags[0] & start0_lane[0]) |
                                   (start_flags[1] & (start1_lane != 2'b10)));
      assign abort_first = xfer & abort_req & (~in_pkt | (start_flags != 2'b00));
      assign closes      = in_pkt & end_flags[0];
      assign next_open   = n_open > 4'sd0;
      assign nostrt_hit  = 1'b0;
    end else begin : g_flat
      assign frame_hit   = xfer & in_pkt & start_flags[0];
      assign nostrt_hit  = xfer & ~in_pkt & ~start_flags[0];
      assign rsvd_hit    = 1'b0;
      assign abort_first = xfer & abort_req & ~in_pkt;
      assign closes      = beat_last;
      assign next_open   = ~beat_last;
    end
  endgenerate

  assign abort_counts = abort_req & in_pkt;
  assign drop_now     = xfer & closes & (aborted | abort_counts);

  always_comb begin
    hit           = '0;
    hit[E_VDROP]  = prev_stall & ~beat_valid;
    hit[E_UNSTAB] = prev_stall & beat_valid & (bundle != prev_bundle);
    hit[E_GAP]    = in_pkt & ~beat_valid;
    hit[E_ABFRST] = abort_first;
    hit[E_ABHOLD] = (abort_req & ~beat_valid) | (prev_stall & prev_abort & ~abort_req);
    hit[E_RSVD]   = rsvd_hit;
    hit[E_FRAME]  = frame_hit;
    hit[E_NOSTRT] = nostrt_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_stall  <= 1'b0;
      prev_abort  <= 1'b0;
      prev_bundle <= '0;
      in_pkt      <= 1'b0;
      aborted     <= 1'b0;
      err_flags   <= '0;
      pkt_dropped <= 1'b0;
    end else begin
      prev_stall  <= stall;
      prev_abort  <= abort_req;
      prev_bundle <= bundle;
      err_flags   <= err_flags | hit;
      pkt_dropped <= drop_now;
      if (xfer) begin
        in_pkt  <= next_open;
        aborted <= closes ? 1'b0 : (aborted | abort_counts);
      end
    end
  end

  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    &(err_flags | ~$past(err_flags)));

  assert_vdrop_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags[E_VDROP]) |-> $past(!beat_valid));

  assert_gap_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags[E_GAP]) |-> $past(!beat_valid));

  assert_nostart_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags[E_NOSTRT]) |-> $past(beat_valid && beat_ready && !start_flags[0]));

  assert_drop_after_xfer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_dropped |-> $past(beat_valid && beat_ready));

  assert_frame_on_xfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags[E_FRAME]) |-> $past(beat_valid && beat_ready));

endmodule

// File: tb/rq_stream_checker_tb.sv
`timescale 1ns/1ps
module rq_stream_checker_tb;
  localparam int DW = 64;

  typedef struct {
    bit         sel;
    logic [7:0] err;
    logic       drop;
    string      req;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic v = 1'b0, r = 1'b0, l = 1'b0, ab = 1'b0;
  logic [DW-1:0] d = '0;
  logic [1:0] sf = '0, s0 = '0, s1 = '0, ef = '0;
  logic [7:0] err_n, err_s;
  logic drop_n, drop_s;

  int checks = 0;
  int fails = 0;
  item_t q[$];
  item_t it;

  always #10 clk = ~clk;

  rq_stream_checker #(.DATA_W(DW), .STRADDLE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .beat_valid(v), .beat_ready(r), .beat_data(d),
    .beat_last(l), .start_flags(sf), .start0_lane(s0), .start1_lane(s1),
    .end_flags(ef), .abort_req(ab), .err_flags(err_n), .pkt_dropped(drop_n));

  rq_stream_checker #(.DATA_W(DW), .STRADDLE(1'b1)) u_dut_s (
    .clk(clk), .rst_n(rst_n), .beat_valid(v), .beat_ready(r), .beat_data(d),
    .beat_last(l), .start_flags(sf), .start0_lane(s0), .start1_lane(s1),
    .end_flags(ef), .abort_req(ab), .err_flags(err_s), .pkt_dropped(drop_s));

  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      it = q.pop_front();
      checks++;
      if (it.sel ? ({err_s, drop_s} !== {it.err, it.drop})
                 : ({err_n, drop_n} !== {it.err, it.drop})) begin
        fails++;
        $display("FAIL %s (%s): got err=%b drop=%b expected err=%b drop=%b",
                 it.req, it.sel ? "straddle" : "flat",
                 it.sel ? err_s : err_n, it.sel ? drop_s : drop_n, it.err, it.drop);
      end
    end
  end

  task automatic beat(input bit iv, input bit ir, input logic [DW-1:0] id, input bit il,
                      input logic [1:0] isf, input logic [1:0] is0, input logic [1:0] is1,
                      input logic [1:0] ief, input bit iab, input bit sel,
                      input logic [7:0] e, input bit dr, input string req);
    item_t x;
    @(negedge clk);
    v = iv; r = ir; d = id; l = il; sf = isf; s0 = is0; s1 = is1; ef = ief; ab = iab;
    x.sel = sel; x.err = e; x.drop = dr; x.req = req;
    q.push_back(x);
  endtask

  task automatic idle(input bit sel, input logic [7:0] e, input string req);
    beat(0, 0, '0, 0, 2'b00, 2'b00, 2'b00, 2'b00, 0, sel, e, 0, req);
  endtask

  task automatic rst_all();
    @(negedge clk);
    v = 0; r = 0; d = '0; l = 0; sf = '0; s0 = '0; s1 = '0; ef = '0; ab = 0;
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_all();
    #1;
    checks++;
    if ({err_n, drop_n, err_s, drop_s} !== '0) begin
      fails++;
      $display("FAIL R1: got %b %b %b %b expected all zero", err_n, drop_n, err_s, drop_s);
    end

    // R11: clean flat packet with a compliant stall
    beat(1, 1, 64'h11, 0, 2'b01, 0, 0, 0, 0, 0, 8'h00, 0, "R11");
    beat(1, 0, 64'h22, 0, 2'b00, 0, 0, 0, 0, 0, 8'h00, 0, "R11");
    beat(1, 1, 64'h22, 0, 2'b00, 0, 0, 0, 0, 0, 8'h00, 0, "R11");
    beat(1, 1, 64'h33, 1, 2'b00, 0, 0, 0, 0, 0, 8'h00, 0, "R11");
    idle(0, 8'h00, "R11");

    // R12: stalled last does not close
    rst_all();
    beat(1, 1, 64'h11, 0, 2'b01, 0, 0, 0, 0, 0, 8'h00, 0, "R12");
    beat(1, 0, 64'h22, 1, 2'b00, 0, 0, 0, 0, 0, 8'h00, 0, "R12");
    beat(1, 0, 64'h22, 1, 2'b00, 0, 0, 0, 0, 0, 8'h00, 0, "R12");
    beat(1, 1, 64'h22, 1, 2'b00, 0, 0, 0, 0, 0, 8'h00, 0, "R12");
    idle(0, 8'h00, "R12");

    // R2 and stickiness
    rst_all();
    beat(1, 0, 64'h11, 1, 2'b01, 0, 0, 0, 0, 0, 8'h00, 0, "R2");
    idle(0, 8'h01, "R2");
    idle(0, 8'h01, "R11");

    // R3
    rst_all();
    beat(1, 0, 64'h11, 1, 2'b01, 0, 0, 0, 0, 0, 8'h00, 0, "R3");
    beat(1, 1, 64'h99, 1, 2'b01, 0, 0, 0, 0, 0, 8'h02, 0, "R3");

    // R4
    rst_all();
    beat(1, 1, 64'h11, 0, 2'b01, 0, 0, 0, 0, 0, 8'h00, 0, "R4");
    idle(0, 8'h04, "R4");

    // R5 flat
    rst_all();
    beat(1, 1, 64'h11, 0, 2'b01, 0, 0, 0, 1, 0, 8'h08, 0, "R5");
    beat(1, 1, 64'h22, 1, 2'b00, 0, 0, 0, 0, 0, 8'h08, 0, "R5");

    // R6
    rst_all();
    beat(0, 0, '0, 0, 2'b00, 0, 0, 0, 1, 0, 8'h10, 0, "R6");
    rst_all();
    beat(1, 1, 64'h11, 0, 2'b01, 0, 0, 0, 0, 0, 8'h00, 0, "R6");
    beat(1, 0, 64'h22, 0, 2'b00, 0, 0, 0, 1, 0, 8'h00, 0, "R6");
    beat(1, 1, 64'h22, 0, 2'b00, 0, 0, 0, 0, 0, 8'h10, 0, "R6");
    beat(1, 1, 64'h33, 1, 2'b00, 0, 0, 0, 0, 0, 8'h10, 0, "R6");

    // R10 sticky abort, run to completion, then early end
    rst_all();
    beat(1, 1, 64'h11, 0, 2'b01, 0, 0, 0, 0, 0, 8'h00, 0, "R10");
    beat(1, 1, 64'h22, 0, 2'b00, 0, 0, 0, 1, 0, 8'h00, 0, "R10");
    beat(1, 1, 64'h33, 0, 2'b00, 0, 0, 0, 0, 0, 8'h00, 0, "R10");
    beat(1, 1, 64'h44, 1, 2'b00, 0, 0, 0, 0, 0, 8'h00, 1, "R10");
    idle(0, 8'h00, "R10");
    beat(1, 1, 64'h55, 0, 2'b01, 0, 0, 0, 0, 0, 8'h00, 0, "R10");
    beat(1, 1, 64'h66, 1, 2'b00, 0, 0, 0, 1, 0, 8'h00, 1, "R10");
    idle(0, 8'h00, "R10");

    // R9
    rst_all();
    beat(1, 1, 64'h11, 1, 2'b00, 0, 0, 0, 0, 0, 8'h80, 0, "R9");

    // R8 flat
    rst_all();
    beat(1, 1, 64'h11, 0, 2'b01, 0, 0, 0, 0, 0, 8'h00, 0, "R8");
    beat(1, 1, 64'h22, 0, 2'b01, 0, 0, 0, 0, 0, 8'h40, 0, "R8");

    // R11 straddle clean sequences
    rst_all();
    beat(1, 1, 64'h11, 1, 2'b01, 2'b00, 2'b00, 2'b00, 0, 1, 8'h00, 0, "R11");
    beat(1, 1, 64'h22, 0, 2'b01, 2'b10, 2'b00, 2'b01, 0, 1, 8'h00, 0, "R11");
    beat(1, 1, 64'h33, 0, 2'b00, 2'b00, 2'b00, 2'b01, 0, 1, 8'h00, 0, "R11");
    beat(1, 1, 64'h44, 0, 2'b11, 2'b00, 2'b10, 2'b01, 0, 1, 8'h00, 0, "R11");
    beat(1, 1, 64'h55, 0, 2'b00, 2'b00, 2'b00, 2'b01, 0, 1, 8'h00, 0, "R11");
    idle(1, 8'h00, "R11");

    // R7
    rst_all();
    beat(1, 1, 64'h11, 0, 2'b10, 2'b00, 2'b10, 2'b00, 0, 1, 8'h20, 0, "R7");
    rst_all();
    beat(1, 1, 64'h11, 0, 2'b01, 2'b01, 2'b00, 2'b01, 0, 1, 8'h20, 0, "R7");
    rst_all();
    beat(1, 1, 64'h11, 0, 2'b11, 2'b00, 2'b00, 2'b01, 0, 1, 8'h20, 0, "R7");
    rst_all();
    beat(1, 1, 64'h11, 0, 2'b01, 2'b00, 2'b00, 2'b00, 0, 1, 8'h00, 0, "R7");
    beat(1, 1, 64'h22, 0, 2'b00, 2'b00, 2'b00, 2'b10, 0, 1, 8'h20, 0, "R7");

    // R8 straddle
    rst_all();
    beat(1, 1, 64'h11, 0, 2'b00, 2'b00, 2'b00, 2'b01, 0, 1, 8'h40, 0, "R8");
    rst_all();
    beat(1, 1, 64'h11, 0, 2'b01, 2'b00, 2'b00, 2'b00, 0, 1, 8'h00, 0, "R8");
    beat(1, 1, 64'h22, 0, 2'b01, 2'b10, 2'b00, 2'b00, 0, 1, 8'h40, 0, "R8");

    // R5 straddle: abort sharing a beat with a start
    rst_all();
    beat(1, 1, 64'h11, 0, 2'b01, 2'b00, 2'b00, 2'b00, 0, 1, 8'h00, 0, "R5");
    beat(1, 1, 64'h22, 0, 2'b01, 2'b10, 2'b00, 2'b01, 1, 1, 8'h08, 1, "R5");
    beat(1, 1, 64'h33, 0, 2'b00, 2'b00, 2'b00, 2'b01, 0, 1, 8'h08, 0, "R5");

    // R10 straddle sticky abort
    rst_all();
    beat(1, 1, 64'h11, 0, 2'b01, 2'b00, 2'b00, 2'b00, 0, 1, 8'h00, 0, "R10");
    beat(1, 1, 64'h22, 0, 2'b00, 2'b00, 2'b00, 2'b00, 1, 1, 8'h00, 0, "R10");
    beat(1, 1, 64'h33, 0, 2'b00, 2'b00, 2'b00, 2'b00, 0, 1, 8'h00, 0, "R10");
    beat(1, 1, 64'h44, 0, 2'b00, 2'b00, 2'b00, 2'b01, 0, 1, 8'h00, 1, "R10");
    idle(1, 8'h00, "R10");

    @(negedge clk);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule